// File: doc/BRIEF.md
# Half-Duplex Echo Suppression Receiver Gate

This block sits between a UART receiver's character assembler and its receive FIFO. On a half-duplex line (RS-485, IrDA) the local receiver hears the local transmitter, so every character sent comes straight back as an echo. When suppression is switched on, the gate drops any character whose stop bit is sampled while the transmitter is busy. It keeps the line marked as echo-prone for a programmable hold window after transmission ends, which covers echoes with a long round-trip delay.

The hold window is set in bit periods by a 4-bit configuration field, with values 0 to 15. One bit period is `TICKS_PER_BIT` baud ticks, 16 by default. The window counts only the baud ticks that arrive after the transmitter goes idle. It starts over from its full length each time the transmitter becomes busy again. When suppression is off, every received character is forwarded unchanged. Deserialisation and driver direction control are handled elsewhere.

Top module: `hdx_echo_gate`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `fifo_wr_en`, `echo_window` and `fifo_wr_data` are all zero.
- R2: With `cfg_suppress_en`=1, a character presented (`rx_char_valid`=1) in a cycle where `tx_busy`=1 produces no `fifo_wr_en` pulse.
- R3: `echo_window` is 1 whenever `tx_busy`=1. After `tx_busy` falls, it stays 1 until exactly `cfg_hold_units`×`TICKS_PER_BIT` baud ticks have been seen with `tx_busy`=0, and then it drops. With `cfg_hold_units`=0 it drops in the same cycle as `tx_busy`.
- R4: With `cfg_suppress_en`=1, a character presented while `echo_window`=1 (including the last cycle before the final tick) produces no write.
- R5: A character presented while `echo_window`=0 produces `fifo_wr_en`=1 in the next cycle, with `fifo_wr_data` equal to the presented byte.
- R6: If `tx_busy` rises again before the hold window expires, the window restarts, and the full `cfg_hold_units`×`TICKS_PER_BIT` idle ticks are needed again.
- R7: With `cfg_suppress_en`=0, every presented character is written with its data unchanged, whatever the values of `tx_busy` and `echo_window`.
- R8: `fifo_wr_en` is a single-cycle pulse. It is asserted only in the cycle after a cycle with `rx_char_valid`=1.
- R9: Baud ticks that arrive while `tx_busy`=1 do not shorten the hold window that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_suppress_en | input | 1 | 1 = drop echoed characters |
| cfg_hold_units | input | HOLD_W | Hold window in bit periods (0 = none) |
| tx_busy | input | 1 | Local transmitter is sending |
| baud_tick | input | 1 | Oversampling tick, TICKS_PER_BIT per bit period |
| rx_char_valid | input | 1 | Strobe at the stop-bit sample of a received character |
| rx_char_data | input | DATA_W | Received character |
| fifo_wr_en | output | 1 | Write strobe to the receive FIFO |
| fifo_wr_data | output | DATA_W | Character to write |
| echo_window | output | 1 | Transmitting or inside the hold window |

## Verification
The bench builds the gate with `TICKS_PER_BIT`=4, `HOLD_W`=4 and `DATA_W`=8. The longest hold window is then only 60 ticks, so every one of the 16 hold settings can be swept in full. For each setting, the bench works out the window length as hold×4. It probes the last tick inside the window and the first tick after it, and places extra ticks during transmission. It also covers the window restarting when transmission resumes mid-hold, and the pass-through mode with suppression off.

// File: rtl/hdx_echo_pkg.sv
package hdx_echo_pkg;

  // Width of a counter that must hold values 0..max_val.
  function automatic int unsigned cnt_width(int unsigned max_val);
    int unsigned w;
    w = 1;
    while ((1 << w) <= max_val) w++;
    return w;
  endfunction

  // Largest hold setting for a field of the given width.
  function automatic int unsigned max_units(int unsigned field_w);
    return (1 << field_w) - 1;
  endfunction

  // Number of idle baud ticks that make up the hold window.
  function automatic int unsigned hold_ticks(int unsigned units, int unsigned tpb);
    return units * tpb;
  endfunction

endpackage

// File: rtl/hdx_hold_timer.sv
module hdx_hold_timer
  import hdx_echo_pkg::*;
#(
  parameter int unsigned HOLD_W        = 4,
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_busy,
  input  logic              baud_tick,
  input  logic [HOLD_W-1:0] cfg_hold_units,
  output logic              echo_window
);

  localparam int unsigned MAX_TICKS = hold_ticks(max_units(HOLD_W), TICKS_PER_BIT);
  localparam int unsigned CNT_W     = cnt_width(MAX_TICKS);

  logic [CNT_W-1:0] hold_left;
  logic [CNT_W-1:0] reload_val;
  logic             hold_running;
  logic             idle_tick;
  logic             armed;

  // Named internal events for the assertions below.
  assign reload_val   = CNT_W'(hold_ticks(32'(cfg_hold_units), TICKS_PER_BIT));
  assign hold_running = (hold_left != '0);
  assign idle_tick    = baud_tick && !tx_busy && hold_running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_left <= '0;
    end else if (tx_busy) begin
      hold_left <= reload_val;
    end else if (idle_tick) begin
      hold_left <= hold_left - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assign echo_window = tx_busy || hold_running;

  // R3: the window cannot close without an idle tick while the line stays quiet.
  p_window_needs_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (echo_window && !tx_busy && !baud_tick) |=> echo_window);

  // R6 / R9: at the end of transmission the full window is loaded, whatever came before.
  p_full_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $fell(tx_busy)) |->
      (hold_left == CNT_W'($past(cfg_hold_units)) * CNT_W'(TICKS_PER_BIT)));

  // R3: an idle tick removes exactly one tick from the window.
  p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_tick) |=> (tx_busy || hold_left == $past(hold_left) - 1'b1));

endmodule

// File: rtl/hdx_rx_gate.sv
module hdx_rx_gate #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              suppress_en,
  input  logic              echo_window,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data
);

  logic blank_now;
  logic accept_evt;
  logic drop_evt;

  // Decision made in the cycle the stop-bit strobe arrives.
  assign blank_now  = suppress_en && echo_window;
  assign accept_evt = rx_valid && !blank_now;
  assign drop_evt   = rx_valid && blank_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_en <= accept_evt;
      if (accept_evt) wr_data <= rx_data;
    end
  end

  // R2 / R4: a blanked character never reaches the FIFO.
  p_drop_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> !wr_en);

  // R5: an accepted character is written one cycle later with its data.
  p_pass_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !echo_window) |=> (wr_en && wr_data == $past(rx_data)));

  // R7: with suppression off everything passes.
  p_pass_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !suppress_en) |=> (wr_en && wr_data == $past(rx_data)));

  // R8: no write without a character in the previous cycle.
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !wr_en);

endmodule

// File: rtl/hdx_echo_gate.sv
module hdx_echo_gate
  import hdx_echo_pkg::*;
#(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned HOLD_W        = 4,
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_suppress_en,
  input  logic [HOLD_W-1:0] cfg_hold_units,
  input  logic              tx_busy,
  input  logic              baud_tick,
  input  logic              rx_char_valid,
  input  logic [DATA_W-1:0] rx_char_data,
  output logic              fifo_wr_en,
  output logic [DATA_W-1:0] fifo_wr_data,
  output logic              echo_window
);

  logic window_w;

  hdx_hold_timer #(
    .HOLD_W        (HOLD_W),
    .TICKS_PER_BIT (TICKS_PER_BIT)
  ) hold_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .tx_busy        (tx_busy),
    .baud_tick      (baud_tick),
    .cfg_hold_units (cfg_hold_units),
    .echo_window    (window_w)
  );

  hdx_rx_gate #(
    .DATA_W (DATA_W)
  ) gate_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .suppress_en (cfg_suppress_en),
    .echo_window (window_w),
    .rx_valid    (rx_char_valid),
    .rx_data     (rx_char_data),
    .wr_en       (fifo_wr_en),
    .wr_data     (fifo_wr_data)
  );

  assign echo_window = window_w;

  // R2: with suppression on, characters arriving during transmission are dropped.
  p_drop_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_char_valid && cfg_suppress_en && tx_busy) |=> !fifo_wr_en);

  // R3: transmission always marks the line as echo-prone.
  p_busy_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> echo_window);

endmodule

// File: tb/hdx_echo_gate_tb.sv
module hdx_echo_gate_tb_top;
  localparam int DW  = 8;
  localparam int HW  = 4;
  localparam int TPB = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, en, busy, tick, rv;
  logic [HW-1:0] hold;
  logic [DW-1:0] rd;
  logic          we, win;
  logic [DW-1:0] wd;

  int errs   = 0;
  int checks = 0;

  hdx_echo_gate #(.DATA_W(DW), .HOLD_W(HW), .TICKS_PER_BIT(TPB)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_suppress_en(en), .cfg_hold_units(hold),
    .tx_busy(busy), .baud_tick(tick), .rx_char_valid(rv), .rx_char_data(rd),
    .fifo_wr_en(we), .fifo_wr_data(wd), .echo_window(win)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      cyc();
      tick = 1'b0;
    end
  endtask

  task automatic send(input logic [DW-1:0] d, input bit exp, input string req);
    rv = 1'b1;
    rd = d;
    cyc();
    rv = 1'b0;
    chk(we == exp, req, int'(we), int'(exp));
    if (exp) chk(wd == d, req, int'(wd), int'(d));
    cyc();
    chk(we == 1'b0, "R8", int'(we), 0);
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b1; busy = 1'b0; tick = 1'b0; rv = 1'b0; rd = '0; hold = '0;
    repeat (3) cyc();
    chk(we == 0 && win == 0 && wd == 0, "R1", int'({we, win}), 0);
    rst_n = 1'b1;
    cyc();
    chk(we == 0 && win == 0 && wd == 0, "R1", int'({we, win}), 0);

    // Sweep of every hold setting.
    for (int h = 0; h < 16; h++) begin
      int n;
      n = h * TPB;
      hold = HW'(h);
      en   = 1'b1;
      busy = 1'b1;
      cyc();
      pulse_ticks(3);                               // R9: ticks while busy
      send(DW'(8'h10 + h), 1'b0, "R2");
      chk(win == 1'b1, "R3", int'(win), 1);
      busy = 1'b0;
      cyc();
      chk(win == (n != 0), "R3", int'(win), int'(n != 0));
      if (n > 0) begin
        pulse_ticks(n - 1);
        chk(win == 1'b1, "R9", int'(win), 1);
        send(DW'(8'h40 + h), 1'b0, "R4");
        pulse_ticks(1);
        chk(win == 1'b0, "R3", int'(win), 0);
      end
      send(DW'(8'h80 + h), 1'b1, "R5");
    end

    // Restart of the hold window when transmission resumes.
    hold = 4'd3;
    busy = 1'b1; cyc(); busy = 1'b0; cyc();
    pulse_ticks(2 * TPB);
    busy = 1'b1; cyc(); busy = 1'b0; cyc();
    pulse_ticks(3 * TPB - 1);
    chk(win == 1'b1, "R6", int'(win), 1);
    send(8'h5A, 1'b0, "R6");
    pulse_ticks(1);
    send(8'h5B, 1'b1, "R6");

    // Suppression disabled.
    en = 1'b0; hold = 4'd15;
    busy = 1'b1; cyc();
    send(8'hA5, 1'b1, "R7");
    busy = 1'b0; cyc();
    chk(win == 1'b1, "R3", int'(win), 1);
    send(8'h3C, 1'b1, "R7");
    en = 1'b1;
    send(8'hC3, 1'b0, "R4");
    pulse_ticks(15 * TPB);
    send(8'hFF, 1'b1, "R5");
    send(8'h00, 1'b1, "R5");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule